// File: doc/BRIEF.md
# Address Translation Abort Priority Unit

This unit is the translation and checking stage of a 16-bit CPU's memory management. A 16-bit virtual address picks one of eight page register pairs by its top three bits. Each pair has a base register and a descriptor register. The base register, scaled by 64, is added to the low 13 address bits to form a physical address of up to 22 bits. In the same cycle, two checks run side by side. One is the rights and length check, driven by the descriptor's access-control and length fields. The other compares the physical address against a memory-limit register to detect non-existent memory.

When both checks fail, the unit resolves the conflict in one fixed way. The memory-management fault always wins: the access aborts through vector 250 (octal), and the sticky non-existent-memory error bit is left as it was. A non-existent-memory abort through vector 4 happens only when the rights check passes. Only that abort sets the sticky error bit. The bit stays set until it is cleared explicitly.

Results are registered. They appear one clock after the access strobe.

Top module: `mmu_abort_prio`

## Requirements
- R1: While reset is asserted, and after it, pa, abort, vector and err_nxm are all zero, and every page base and descriptor register holds zero.
- R2: A write with pg_we high stores pg_wdata into page pg_idx: into the descriptor when pg_sel_desc is 1, and into the base register when it is 0. The new value is used by accesses from the next cycle on.
- R3: With chk_en high, pa = base × 64 + va[12:0] for page va[15:13]. If ext22_en is low, the result is cut to its low 18 bits.
- R4: With chk_en low, pa is va zero-extended and no memory-management abort is raised. The non-existent-memory check still applies.
- R5: The access-control field is descriptor bits 2:0. Value 6 allows reads and writes. Value 2 allows reads, and a write (wr = 1) faults. Values 0, 7 and every other value fault. A fault gives abort = 1 with vector = 9'o250 (decimal 168).
- R6: A block number va[12:6] greater than the length field in descriptor bits 14:8 faults with vector 9'o250.
- R7: When pa ≥ mem_lim × 64 and there is no rights or length fault, the unit aborts with vector = 9'o004 and sets err_nxm.
- R8: When a rights or length fault and a non-existent-memory condition occur together, vector is 9'o250 and err_nxm is left unchanged.
- R9: Results are registered. abort and vector reflect the access strobed in the previous cycle, and are zero after a cycle without acc_vld. pa is updated only on a strobed access and holds its value otherwise.
- R10: err_nxm is sticky and is cleared by err_clr. If a setting abort and err_clr fall in the same cycle, err_nxm ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Access strobe |
| va | input | 16 | Virtual address |
| wr | input | 1 | 1 = write access, 0 = read access |
| chk_en | input | 1 | Enables translation and rights checking |
| ext22_en | input | 1 | Enables the full 22-bit physical address |
| mem_lim | input | 16 | Installed memory size, in 64-byte blocks |
| err_clr | input | 1 | Clears the sticky error bit |
| pg_we | input | 1 | Page register write enable |
| pg_sel_desc | input | 1 | 1 = write the descriptor, 0 = write the base register |
| pg_idx | input | 3 | Page register pair to write |
| pg_wdata | input | 16 | Page register write data |
| pa | output | 22 | Physical address of the last access |
| abort | output | 1 | Abort request |
| vector | output | 9 | Trap vector (0, 9'o004 or 9'o250) |
| err_nxm | output | 1 | Sticky non-existent-memory error bit |

## Verification
The assertions check the following on every cycle:
- A memory-management abort never coincides with a rising error bit.
- A vector-4 abort always leaves the error bit set.
- The vector is always one of the two legal codes.
- Idle cycles stay quiet.
- The error bit holds unless it is cleared.
- A reserved access-control code always faults.

The remaining behaviour can only be shown by the bench's scenarios, because it depends on matching computed values. That covers the exact physical address arithmetic, the 18-bit cut, the length comparison, and the double-fault ordering. The bench checks these against a behavioural model on every clock.

// File: rtl/mmu_prio_pkg.sv
package mmu_prio_pkg;
    localparam int VA_W        = 16;
    localparam int REG_W       = 16;
    localparam int PA_W        = 22;
    localparam int PA_NARROW_W = 18;
    localparam int PG_IDX_W    = 3;
    localparam int NPAGE       = 1 << PG_IDX_W;
    localparam int OFS_W       = 6;
    localparam int BLK_W       = 7;
    localparam int PAGE_W      = BLK_W + OFS_W;
    localparam int ACF_W       = 3;
    localparam int PLF_LSB     = 8;
    localparam int VEC_W       = 9;

    localparam logic [ACF_W-1:0] ACF_RO = 3'd2;
    localparam logic [ACF_W-1:0] ACF_RW = 3'd6;
    localparam logic [ACF_W-1:0] ACF_RSVD = 3'd7;

    localparam logic [VEC_W-1:0] VEC_NONE = '0;
    localparam logic [VEC_W-1:0] VEC_MMU  = 9'o250;
    localparam logic [VEC_W-1:0] VEC_NXM  = 9'o004;

    typedef struct packed {
        logic [PA_W-1:0]  pa;
        logic             abort;
        logic [VEC_W-1:0] vec;
        logic             err_nxm;
    } stage_t;
endpackage

// File: rtl/mmu_page_file.sv
module mmu_page_file
    import mmu_prio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                sel_desc,
    input  logic [PG_IDX_W-1:0] widx,
    input  logic [REG_W-1:0]    wdata,
    input  logic [PG_IDX_W-1:0] ridx,
    output logic [REG_W-1:0]    base_o,
    output logic [REG_W-1:0]    desc_o
);
    logic [REG_W-1:0] base_q [NPAGE];
    logic [REG_W-1:0] desc_q [NPAGE];

    for (genvar g = 0; g < NPAGE; g++) begin : g_page
        logic [REG_W-1:0] base_d, desc_d;
        always_comb begin
            base_d = base_q[g];
            desc_d = desc_q[g];
            if (we && widx == PG_IDX_W'(g)) begin
                if (sel_desc) desc_d = wdata;
                else          base_d = wdata;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                desc_q[g] <= '0;
            end else begin
                base_q[g] <= base_d;
                desc_q[g] <= desc_d;
            end
        end
    end

    assign base_o = base_q[ridx];
    assign desc_o = desc_q[ridx];
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_prio_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic [REG_W-1:0] base,
    input  logic             chk_en,
    input  logic             ext22_en,
    output logic [PA_W-1:0]  pa
);
    localparam logic [PA_W-1:0] NARROW_MASK = PA_W'((1 << PA_NARROW_W) - 1);
    logic [PA_W-1:0] wide;

    always_comb begin
        wide = {base, {OFS_W{1'b0}}} + PA_W'(va[PAGE_W-1:0]);
        if (!chk_en)        pa = PA_W'(va);
        else if (!ext22_en) pa = wide & NARROW_MASK;
        else                pa = wide;
    end
endmodule

// File: rtl/mmu_rights.sv
module mmu_rights
    import mmu_prio_pkg::*;
(
    input  logic             chk_en,
    input  logic             wr,
    input  logic [REG_W-1:0] desc,
    input  logic [BLK_W-1:0] blk,
    output logic             fault
);
    logic [ACF_W-1:0] acf;
    logic [BLK_W-1:0] plf;
    logic             acf_bad, len_bad;

    always_comb begin
        acf = desc[ACF_W-1:0];
        plf = desc[PLF_LSB +: BLK_W];
        unique case (acf)
            ACF_RW:  acf_bad = 1'b0;
            ACF_RO:  acf_bad = wr;
            default: acf_bad = 1'b1;
        endcase
        len_bad = blk > plf;
        fault   = chk_en && (acf_bad || len_bad);
    end

    always_comb begin
        if (chk_en && acf == ACF_RSVD)
            assert_rsvd_denies_R5: assert (fault);
    end
endmodule

// File: rtl/mmu_abort_prio.sv
module mmu_abort_prio
    import mmu_prio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_vld,
    input  logic [VA_W-1:0]     va,
    input  logic                wr,
    input  logic                chk_en,
    input  logic                ext22_en,
    input  logic [REG_W-1:0]    mem_lim,
    input  logic                err_clr,
    input  logic                pg_we,
    input  logic                pg_sel_desc,
    input  logic [PG_IDX_W-1:0] pg_idx,
    input  logic [REG_W-1:0]    pg_wdata,
    output logic [PA_W-1:0]     pa,
    output logic                abort,
    output logic [VEC_W-1:0]    vector,
    output logic                err_nxm
);
    logic [REG_W-1:0] base, desc;
    logic [PA_W-1:0]  pa_c;
    logic             mmu_fault, nxm_hit;
    stage_t           st_d, st_q;

    mmu_page_file u_pages (
        .clk(clk), .rst_n(rst_n), .we(pg_we), .sel_desc(pg_sel_desc),
        .widx(pg_idx), .wdata(pg_wdata), .ridx(va[VA_W-1 -: PG_IDX_W]),
        .base_o(base), .desc_o(desc)
    );

    mmu_xlate u_xlate (
        .va(va), .base(base), .chk_en(chk_en), .ext22_en(ext22_en), .pa(pa_c)
    );

    mmu_rights u_rights (
        .chk_en(chk_en), .wr(wr), .desc(desc),
        .blk(va[PAGE_W-1:OFS_W]), .fault(mmu_fault)
    );

    assign nxm_hit = pa_c >= {mem_lim, {OFS_W{1'b0}}};

    always_comb begin
        st_d       = st_q;
        st_d.abort = 1'b0;
        st_d.vec   = VEC_NONE;
        if (err_clr) st_d.err_nxm = 1'b0;
        if (acc_vld) begin
            st_d.pa = pa_c;
            if (mmu_fault) begin
                st_d.abort = 1'b1;
                st_d.vec   = VEC_MMU;
            end else if (nxm_hit) begin
                st_d.abort   = 1'b1;
                st_d.vec     = VEC_NXM;
                st_d.err_nxm = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pa      = st_q.pa;
    assign abort   = st_q.abort;
    assign vector  = st_q.vec;
    assign err_nxm = st_q.err_nxm;

    assert_prio_keeps_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && vector == VEC_MMU) |-> !$rose(err_nxm));
    assert_nxm_sets_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && vector == VEC_NXM) |-> err_nxm);
    assert_vec_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (vector == VEC_MMU || vector == VEC_NXM));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |=> (!abort && vector == VEC_NONE));
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_nxm && !err_clr) |=> err_nxm);
    assert_chk_off_no_mmu_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !chk_en) |=> vector != VEC_MMU);
endmodule

// File: tb/mmu_abort_prio_tb.sv
`timescale 1ns/1ps
module mmu_abort_prio_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_vld = 0, wr = 0, chk_en = 0, ext22_en = 0, err_clr = 0;
    logic [15:0] va = 0, mem_lim = 16'hFFFF, pg_wdata = 0;
    logic        pg_we = 0, pg_sel_desc = 0;
    logic [2:0]  pg_idx = 0;
    logic [21:0] pa;
    logic        abort, err_nxm;
    logic [8:0]  vector;

    int n_tests = 0, n_fail = 0;
    string cur_req = "R1";

    // behavioural reference state
    int unsigned m_base [8];
    int unsigned m_desc [8];
    int unsigned e_pa = 0, e_vec = 0;
    bit e_abort = 0, e_err = 0;

    always #2.5 clk = ~clk;

    mmu_abort_prio dut_i (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .va(va), .wr(wr),
        .chk_en(chk_en), .ext22_en(ext22_en), .mem_lim(mem_lim), .err_clr(err_clr),
        .pg_we(pg_we), .pg_sel_desc(pg_sel_desc), .pg_idx(pg_idx), .pg_wdata(pg_wdata),
        .pa(pa), .abort(abort), .vector(vector), .err_nxm(err_nxm)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_base[i]) begin m_base[i] = 0; m_desc[i] = 0; end
            e_pa = 0; e_abort = 0; e_vec = 0; e_err = 0;
        end else begin
            int unsigned pg, b, d, acf, lim, a;
            bit flt, nxm;
            pg = va >> 13;
            b = m_base[pg];
            d = m_desc[pg];
            acf = d & 7;
            if (chk_en) begin
                a = (b * 64 + (va & 16'h1FFF)) & 22'h3FFFFF;
                if (!ext22_en) a = a % (1 << 18);
            end else a = va;
            flt = 0;
            if (chk_en) begin
                if (!(acf == 6 || (acf == 2 && !wr))) flt = 1;
                if (((va >> 6) & 127) > ((d >> 8) & 127)) flt = 1;
            end
            lim = mem_lim * 64;
            nxm = a >= lim;
            e_abort = 0; e_vec = 0;
            if (err_clr) e_err = 0;
            if (acc_vld) begin
                e_pa = a;
                if (flt) begin e_abort = 1; e_vec = 168; end
                else if (nxm) begin e_abort = 1; e_vec = 4; e_err = 1; end
            end
            if (pg_we) begin
                if (pg_sel_desc) m_desc[pg_idx] = pg_wdata;
                else             m_base[pg_idx] = pg_wdata;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (pa != e_pa || abort != e_abort || vector != e_vec || err_nxm != e_err) begin
                n_fail++;
                $display("FAIL %s: pa=%h abort=%0d vec=%0o err=%0d expected pa=%h abort=%0d vec=%0o err=%0d",
                         cur_req, pa, abort, vector, err_nxm, e_pa, e_abort, e_vec, e_err);
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
        acc_vld = 0; pg_we = 0; err_clr = 0;
    endtask

    task automatic wpage(input int idx, input bit dsc, input logic [15:0] v);
        @(negedge clk); #1;
        acc_vld = 0; err_clr = 0;
        pg_we = 1; pg_idx = 3'(idx); pg_sel_desc = dsc; pg_wdata = v;
    endtask

    task automatic acc(input logic [15:0] a, input bit w);
        @(negedge clk); #1;
        pg_we = 0; err_clr = 0;
        acc_vld = 1; va = a; wr = w;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #7;
        n_tests++;
        if (pa != 0 || abort || vector != 0 || err_nxm) begin
            n_fail++;
            $display("FAIL R1: pa=%h abort=%0d vec=%0o err=%0d expected all zero", pa, abort, vector, err_nxm);
        end
        @(negedge clk); #1 rst_n = 1;
        cur_req = "R1"; step();
        acc(16'hC0A5, 0);                 // zero page regs, checking off
        // R2 R3: writes then translation
        cur_req = "R2"; chk_en = 1; ext22_en = 1;
        wpage(6, 0, 16'h8123); wpage(6, 1, 16'h7F06);
        cur_req = "R3"; acc(16'hC0A5, 0); acc(16'hDFFF, 1);
        ext22_en = 0; acc(16'hC0A5, 0); ext22_en = 1;
        wpage(1, 0, 16'h0040); wpage(1, 1, 16'h7F06);
        acc(16'h2001, 1); step();
        // R4 checking off
        cur_req = "R4"; wpage(2, 1, 16'h0000); chk_en = 0;
        acc(16'h4321, 1); acc(16'hFFFF, 0);
        chk_en = 1;
        // R5 access control codes
        cur_req = "R5";
        wpage(3, 1, 16'h7F02); acc(16'h6010, 0); acc(16'h6010, 1);
        wpage(3, 1, 16'h7F00); acc(16'h6010, 0);
        wpage(3, 1, 16'h7F07); acc(16'h6010, 0);
        wpage(3, 1, 16'h7F03); acc(16'h6010, 1);
        wpage(3, 1, 16'h7F06); acc(16'h6010, 1);
        // R6 length
        cur_req = "R6"; wpage(4, 1, 16'h0506);
        acc(16'h8000 | (5 << 6) | 3, 0); acc(16'h8000 | (6 << 6), 0); acc(16'h9FFF, 1);
        // R7 nxm with rights ok
        cur_req = "R7"; wpage(5, 0, 16'h3000); wpage(5, 1, 16'h7F06);
        mem_lim = 16'h3000; acc(16'hA000, 0); acc(16'hA000, 1);
        cur_req = "R9"; step(); step();
        // R10 clear and set-wins
        cur_req = "R10"; @(negedge clk); #1 err_clr = 1; step();
        cur_req = "R10"; @(negedge clk); #1 acc_vld = 1; va = 16'hA040; wr = 0; err_clr = 1; step();
        @(negedge clk); #1 err_clr = 1; step();
        // R8 double fault
        cur_req = "R8"; wpage(5, 1, 16'h7F07); acc(16'hA000, 0);
        wpage(5, 1, 16'h0006); acc(16'hA0C0, 0);
        chk_en = 0; cur_req = "R4"; mem_lim = 16'h0100; acc(16'h4000, 0);
        chk_en = 1; cur_req = "R9"; mem_lim = 16'hFFFF;
        step(); step(); step();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule